// File: doc/BRIEF.md
# Mode-Banked UART Control Register Bank

This block is the control and status register bank of a UART that oversamples each bit sixteen times. Software reaches it over a plain 16-bit word bus: a 4-bit offset, a write strobe with write data, and combinational read data. The value last written to the line control register picks one of three access modes. Each mode places a different register behind several shared offsets. Two further gates hide some registers: an enhanced-enable bit in the feature register and a submode bit in the modem control register.

The block drives the divisor, frame format, FIFO enable, interrupt enables, modem control, FIFO trigger and transmit-control bytes, and an engine enable toward the serial datapath. It takes two FIFO status flags back in.

Two state machines run the block. The access-mode machine has the states ACC_OPER, ACC_CFG_A and ACC_CFG_B. It changes state only on a write to the line control register:
- writing 0xBF moves it to ACC_CFG_B;
- writing any other value with bit 7 set moves it to ACC_CFG_A;
- writing a value with bit 7 clear moves it to ACC_OPER.

The soft-reset sequencer has the states SEQ_BUSY and SEQ_READY:
- a hardware reset, or a start request while in SEQ_READY, leads to SEQ_BUSY;
- SEQ_BUSY leads back to SEQ_READY after a fixed count of cycles.

While the sequencer is in SEQ_BUSY, every register is held at its default and bus writes are dropped.

Top module: `uart_regbank`

## Requirements
- R1: The line control byte at offset 3 can be read and written in every mode. Writing 0xBF selects configuration mode B. Any other value with bit 7 set selects configuration mode A. A value with bit 7 clear selects operational mode. The new mode applies from the next cycle.
- R2: In mode B, offset 2 is the feature register, and its bit 4 is the enhanced enable. In mode A and in operational mode, offset 2 is the FIFO control register, and its bit 0 drives `fifo_en`.
- R3: The trigger-level byte (offset 6) and the transmit-control byte (offset 7) are visible only while enhanced enable is 1 and modem control bit 6 is 1, in any mode. Otherwise they read 0, and writes to them are dropped.
- R4: In operational mode, offset 1 is the interrupt enable byte. Its bits [7:4] accept a write only while enhanced enable is 1. Otherwise those bits keep their value, and bits [3:0] still update.
- R5: In either configuration mode, offsets 0 and 1 are the divisor low and high bytes. In operational mode, offset 0 reads 0.
- R6: The mode register at offset 8 has bits [2:0] and resets to 7. `engine_en` is 1 exactly when that field is 0, which is normal 16x UART operation.
- R7: `divisor` takes the value {high byte, low byte} one cycle after each edge at which the engine is disabled. It holds its value while the engine is enabled.
- R8: Writing 1 to bit 1 at offset 9 starts a soft reset, and so does a hardware reset. For the next 4 cycles every register returns to its default (line control 0, mode field 7, all others 0), bus writes are dropped, and the done flag is 0. The done flag is `reset_done` and bit 0 at offset 10. After those 4 cycles the done flag reads 1.
- R9: In operational mode and mode A, offset 5 is line status: bit 0 is `rx_avail` and bit 5 is `tx_empty`. In mode B, offset 5 reads 0.
- R10: Line control bits [1:0] give `word_len` (3 means 8 data bits), bit 2 gives `two_stop` and bit 3 gives `parity_en`. The value 0x03 therefore selects 8 data bits, no parity and 1 stop bit.
- R11: In mode A and in operational mode, offset 4 is the modem control byte, which drives `modem_ctrl`. In mode B, offset 4 reads 0. Offsets 11 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data (low byte used) |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rx_avail | input | 1 | Receive FIFO holds data |
| tx_empty | input | 1 | Transmit FIFO is empty |
| divisor | output | 16 | Baud divisor for the 16x engine |
| word_len | output | 2 | Data bits minus 5 |
| two_stop | output | 1 | Second stop bit |
| parity_en | output | 1 | Parity enabled |
| fifo_en | output | 1 | FIFOs enabled |
| irq_en | output | 8 | Interrupt enable byte |
| modem_ctrl | output | 8 | Modem control byte |
| trig_lvl | output | 8 | FIFO trigger-level byte |
| tx_ctl | output | 8 | Transmit-control byte |
| engine_en | output | 1 | Serial engine running |
| reset_done | output | 1 | Soft reset finished |

## Verification
If the access-mode machine is in the wrong state, the error shows up on the first read after the line control write. Offsets 0, 1, 2, 4 and 5 then return the register that belongs to a different mode, or they return zero. The bench therefore sweeps all 256 line control values and reads every shared offset after each one.

A stuck gate on the interrupt enable or trigger registers shows up on the next read-back and on the output ports. A divisor that leaks through while the engine runs shows up on `divisor` one cycle after the divisor write.

A sequencer that counts wrongly moves the rising edge of `reset_done` away from the fourth cycle. A register that the soft reset misses reads back nonzero once `reset_done` is high again.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    typedef enum logic [1:0] {
        ACC_OPER  = 2'd0,
        ACC_CFG_A = 2'd1,
        ACC_CFG_B = 2'd2
    } acc_mode_e;

    typedef enum logic {
        SEQ_BUSY  = 1'b0,
        SEQ_READY = 1'b1
    } seq_state_e;

    localparam int unsigned OFS_DIV_LO = 0;
    localparam int unsigned OFS_DIV_HI = 1;
    localparam int unsigned OFS_FEAT   = 2;
    localparam int unsigned OFS_LCR    = 3;
    localparam int unsigned OFS_MCR    = 4;
    localparam int unsigned OFS_LSR    = 5;
    localparam int unsigned OFS_TLR    = 6;
    localparam int unsigned OFS_TCR    = 7;
    localparam int unsigned OFS_MDR    = 8;
    localparam int unsigned OFS_SYSC   = 9;
    localparam int unsigned OFS_SYSS   = 10;

    localparam int unsigned BIT_ENH     = 4;
    localparam int unsigned BIT_SUBMODE = 6;
    localparam int unsigned BIT_SRST    = 1;
    localparam int unsigned BIT_FIFOEN  = 0;
    localparam int unsigned BIT_RXAV    = 0;
    localparam int unsigned BIT_TXEMPTY = 5;

    localparam logic [7:0]  LCR_CFG_B   = 8'hBF;
    localparam int unsigned MDR_W       = 3;
    localparam logic [2:0]  MDR_IDLE    = 3'h7;

endpackage

// File: rtl/uart_regbank_mode.sv
module uart_regbank_mode
    import uart_regbank_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [REG_W-1:0] lcr_in,
    output acc_mode_e        mode,
    output logic [REG_W-1:0] lcr
);

    acc_mode_e  mode_nxt;
    logic       is_cfg_b;

    assign is_cfg_b = (lcr_in == REG_W'(LCR_CFG_B));

    always_comb begin
        mode_nxt = mode;
        if (clr) begin
            mode_nxt = ACC_OPER;
        end else if (load) begin
            unique case ({is_cfg_b, lcr_in[REG_W-1]})
                2'b11:   mode_nxt = ACC_CFG_B;
                2'b01:   mode_nxt = ACC_CFG_A;
                default: mode_nxt = ACC_OPER;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= ACC_OPER;
            lcr  <= '0;
        end else begin
            mode <= mode_nxt;
            if (clr)       lcr <= '0;
            else if (load) lcr <= lcr_in;
        end
    end

    p_cfgb_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr && is_cfg_b) |=> (mode == ACC_CFG_B));
    p_cfga_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr && !is_cfg_b && lcr_in[REG_W-1]) |=> (mode == ACC_CFG_A));
    p_oper_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr && !lcr_in[REG_W-1]) |=> (mode == ACC_OPER));
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(mode));

endmodule

// File: rtl/uart_regbank_rstseq.sv
module uart_regbank_rstseq
    import uart_regbank_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    seq_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            SEQ_READY: begin
                if (start) begin
                    state_nxt = SEQ_BUSY;
                    cnt_nxt   = '0;
                end
            end
            SEQ_BUSY: begin
                if (cnt == CNT_LAST) begin
                    state_nxt = SEQ_READY;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: state_nxt = SEQ_BUSY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_BUSY;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        busy = (state == SEQ_BUSY);
        done = (state == SEQ_READY);
    end

    p_start_clears_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);
    p_done_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    p_busy_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < CNT_W'(RST_CYCLES)));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned BUS_W      = 16,
    parameter int unsigned REG_W      = 8,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic               rx_avail,
    input  logic               tx_empty,
    output logic [2*REG_W-1:0] divisor,
    output logic [1:0]         word_len,
    output logic               two_stop,
    output logic               parity_en,
    output logic               fifo_en,
    output logic [REG_W-1:0]   irq_en,
    output logic [REG_W-1:0]   modem_ctrl,
    output logic [REG_W-1:0]   trig_lvl,
    output logic [REG_W-1:0]   tx_ctl,
    output logic               engine_en,
    output logic               reset_done
);

    localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(OFS_DIV_LO);
    localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(OFS_DIV_HI);
    localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'(OFS_FEAT);
    localparam logic [ADDR_W-1:0] A_LCR  = ADDR_W'(OFS_LCR);
    localparam logic [ADDR_W-1:0] A_MCR  = ADDR_W'(OFS_MCR);
    localparam logic [ADDR_W-1:0] A_LSR  = ADDR_W'(OFS_LSR);
    localparam logic [ADDR_W-1:0] A_TLR  = ADDR_W'(OFS_TLR);
    localparam logic [ADDR_W-1:0] A_TCR  = ADDR_W'(OFS_TCR);
    localparam logic [ADDR_W-1:0] A_MDR  = ADDR_W'(OFS_MDR);
    localparam logic [ADDR_W-1:0] A_SYSC = ADDR_W'(OFS_SYSC);
    localparam logic [ADDR_W-1:0] A_SYSS = ADDR_W'(OFS_SYSS);
    localparam int unsigned NIB = REG_W / 2;

    typedef struct packed {
        logic [REG_W-1:0] efr;
        logic [REG_W-1:0] fcr;
        logic [REG_W-1:0] mcr;
        logic [REG_W-1:0] ier;
        logic [REG_W-1:0] dlo;
        logic [REG_W-1:0] dhi;
        logic [REG_W-1:0] tlr;
        logic [REG_W-1:0] tcr;
        logic [MDR_W-1:0] mdr;
    } regs_t;

    localparam regs_t REGS_DEFAULT = '{efr: '0, fcr: '0, mcr: '0, ier: '0,
                                       dlo: '0, dhi: '0, tlr: '0, tcr: '0,
                                       mdr: MDR_IDLE};

    regs_t            cur, nxt;
    acc_mode_e        mode;
    logic [REG_W-1:0] lcr;
    logic             busy, srst_start, lcr_load;
    logic             in_cfg, in_b, enh, sub;
    logic [REG_W-1:0] wbyte, lsr;
    logic             unused_hi;

    assign wbyte      = bus_wdata[REG_W-1:0];
    assign unused_hi  = ^bus_wdata[BUS_W-1:REG_W];
    assign srst_start = bus_wr && reset_done && (bus_addr == A_SYSC) && bus_wdata[BIT_SRST];
    assign lcr_load   = bus_wr && !busy && (bus_addr == A_LCR);

    uart_regbank_rstseq #(.RST_CYCLES(RST_CYCLES)) u_rstseq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (busy),
        .done  (reset_done)
    );

    uart_regbank_mode #(.REG_W(REG_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (busy),
        .load   (lcr_load),
        .lcr_in (wbyte),
        .mode   (mode),
        .lcr    (lcr)
    );

    always_comb begin
        in_cfg = (mode != ACC_OPER);
        in_b   = (mode == ACC_CFG_B);
        enh    = cur.efr[BIT_ENH];
        sub    = enh && cur.mcr[BIT_SUBMODE];
    end

    // Register write path: visibility gates decide which store a write lands in.
    always_comb begin
        nxt = cur;
        if (busy) begin
            nxt = REGS_DEFAULT;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_DLO:  if (in_cfg) nxt.dlo = wbyte;
                A_DHI: begin
                    if (in_cfg)   nxt.dhi = wbyte;
                    else if (enh) nxt.ier = wbyte;
                    else          nxt.ier = {cur.ier[REG_W-1:NIB], wbyte[NIB-1:0]};
                end
                A_FEAT: if (in_b) nxt.efr = wbyte; else nxt.fcr = wbyte;
                A_MCR:  if (!in_b) nxt.mcr = wbyte;
                A_TLR:  if (sub) nxt.tlr = wbyte;
                A_TCR:  if (sub) nxt.tcr = wbyte;
                A_MDR:  nxt.mdr = wbyte[MDR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= REGS_DEFAULT;
        else        cur <= nxt;
    end

    // Divisor output only follows the latches while the engine is stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          divisor <= '0;
        else if (!engine_en) divisor <= {cur.dhi, cur.dlo};
    end

    always_comb begin
        lsr = '0;
        lsr[BIT_RXAV]    = rx_avail;
        lsr[BIT_TXEMPTY] = tx_empty;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_DLO:  if (in_cfg) bus_rdata = BUS_W'(cur.dlo);
            A_DHI:  bus_rdata = in_cfg ? BUS_W'(cur.dhi) : BUS_W'(cur.ier);
            A_FEAT: bus_rdata = in_b ? BUS_W'(cur.efr) : BUS_W'(cur.fcr);
            A_LCR:  bus_rdata = BUS_W'(lcr);
            A_MCR:  if (!in_b) bus_rdata = BUS_W'(cur.mcr);
            A_LSR:  if (!in_b) bus_rdata = BUS_W'(lsr);
            A_TLR:  if (sub) bus_rdata = BUS_W'(cur.tlr);
            A_TCR:  if (sub) bus_rdata = BUS_W'(cur.tcr);
            A_MDR:  bus_rdata = BUS_W'(cur.mdr);
            A_SYSC: bus_rdata = BUS_W'(busy) << BIT_SRST;
            A_SYSS: bus_rdata = BUS_W'(reset_done);
            default: ;
        endcase
    end

    always_comb begin
        word_len   = lcr[1:0];
        two_stop   = lcr[2];
        parity_en  = lcr[3];
        fifo_en    = cur.fcr[BIT_FIFOEN];
        irq_en     = cur.ier;
        modem_ctrl = cur.mcr;
        trig_lvl   = cur.tlr;
        tx_ctl     = cur.tcr;
        engine_en  = (cur.mdr == '0);
    end

    p_ier_hi_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == A_DHI && mode == ACC_OPER && !enh)
        |=> (irq_en[REG_W-1:NIB] == $past(irq_en[REG_W-1:NIB])));
    p_div_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        engine_en |=> $stable(divisor));
    p_tl_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !busy && bus_addr == A_TLR && !sub) |=> $stable(trig_lvl));
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > A_SYSS) |-> (bus_rdata == '0));
    p_busy_holds_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!engine_en && fifo_en == 1'b0));

endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_avail = 1'b1;
    logic        tx_empty = 1'b0;
    logic [15:0] divisor;
    logic [1:0]  word_len;
    logic        two_stop, parity_en, fifo_en, engine_en, reset_done;
    logic [7:0]  irq_en, modem_ctrl, trig_lvl, tx_ctl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_regbank i_uart_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_avail(rx_avail),
        .tx_empty(tx_empty), .divisor(divisor), .word_len(word_len),
        .two_stop(two_stop), .parity_en(parity_en), .fifo_en(fifo_en),
        .irq_en(irq_en), .modem_ctrl(modem_ctrl), .trig_lvl(trig_lvl),
        .tx_ctl(tx_ctl), .engine_en(engine_en), .reset_done(reset_done)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // 0 operational, 1 config A, 2 config B
    function automatic int mode_of(input logic [7:0] v);
        if (v == 8'hBF) return 2;
        if (v[7])       return 1;
        return 0;
    endfunction

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R8 done low after hw reset", reset_done, 0);
        repeat (3) @(negedge clk);
        chk("R8 done still low at cycle 3", reset_done, 0);
        @(negedge clk);
        chk("R8 done high at cycle 4", reset_done, 1);
        chk("R6 engine off at reset", engine_en, 0);
        chk("R7 divisor reset", divisor, 0);
        rd(4'd8, r); chk("R6 mode field default", r, 16'h7);
        rd(4'd3, r); chk("R1 lcr default", r, 0);

        wr(4'd3, 16'h0080);
        wr(4'd0, 16'h005A);
        wr(4'd1, 16'h0001);
        wr(4'd4, 16'h0003);
        wr(4'd2, 16'h0001);
        chk("R2 fifo_en from control bit0", fifo_en, 1);

        for (int v = 0; v < 256; v++) begin
            wr(4'd3, 16'(v));
            m = mode_of(8'(v));
            tx_empty = v[0];
            rd(4'd3, r); chk("R1 lcr readback", r, 16'(v));
            chk("R10 word_len", word_len, 32'(v[1:0]));
            chk("R10 stop/parity", {two_stop, parity_en}, {v[2], v[3]});
            rd(4'd0, r); chk("R5 offset0", r, (m != 0) ? 16'h5A : 16'h0);
            rd(4'd1, r); chk("R5 offset1", r, (m != 0) ? 16'h01 : 16'h0);
            rd(4'd2, r); chk("R2 offset2", r, (m == 2) ? 16'h0 : 16'h1);
            rd(4'd4, r); chk("R11 offset4", r, (m == 2) ? 16'h0 : 16'h3);
            rd(4'd5, r); chk("R9 line status", r, (m == 2) ? 16'h0 : (16'(v[0]) << 5) | 16'h1);
        end

        chk("R7 divisor follows while stopped", divisor, 16'h015A);
        wr(4'd8, 16'h0000);
        chk("R6 engine on for field 0", engine_en, 1);
        wr(4'd0, 16'h0033);
        repeat (2) @(negedge clk);
        chk("R7 divisor frozen while running", divisor, 16'h015A);
        rd(4'd0, r); chk("R5 low byte stored", r, 16'h33);
        wr(4'd8, 16'h0007);
        chk("R7 no update on stop edge", divisor, 16'h015A);
        @(negedge clk);
        chk("R7 update one cycle later", divisor, 16'h0133);

        wr(4'd3, 16'h0000);
        for (int w = 0; w < 256; w++) begin
            wr(4'd1, 16'(w));
            rd(4'd1, r); chk("R4 upper locked", r, 16'(w & 8'h0F));
        end
        wr(4'd3, 16'h00BF);
        wr(4'd2, 16'h0010);
        rd(4'd2, r); chk("R2 feature reg in mode B", r, 16'h10);
        wr(4'd3, 16'h0000);
        for (int w = 0; w < 256; w++) begin
            wr(4'd1, 16'(w));
            rd(4'd1, r); chk("R4 full write enhanced", r, 16'(w));
        end
        chk("R4 irq_en port", irq_en, 8'hFF);

        wr(4'd6, 16'h003C);
        chk("R3 hidden without submode", trig_lvl, 0);
        rd(4'd6, r); chk("R3 reads 0 without submode", r, 0);
        wr(4'd3, 16'h00BF);
        wr(4'd2, 16'h0000);
        wr(4'd3, 16'h0000);
        wr(4'd1, 16'h0000);
        rd(4'd1, r); chk("R4 upper kept after enhanced off", r, 16'hF0);
        wr(4'd3, 16'h0080);
        wr(4'd4, 16'h0043);
        chk("R11 modem_ctrl port", modem_ctrl, 8'h43);
        wr(4'd6, 16'h003C);
        chk("R3 hidden without enhanced", trig_lvl, 0);
        wr(4'd3, 16'h00BF);
        wr(4'd2, 16'h0010);
        rd(4'd6, r); chk("R3 no earlier write landed", r, 0);
        wr(4'd6, 16'h003C);
        wr(4'd7, 16'h00C3);
        rd(4'd6, r); chk("R3 trigger readback", r, 16'h3C);
        rd(4'd7, r); chk("R3 tx control readback", r, 16'hC3);
        chk("R3 ports", {trig_lvl, tx_ctl}, 16'h3CC3);

        wr(4'd3, 16'h0003);
        chk("R10 8N1", {word_len, two_stop, parity_en}, 4'b1100);
        for (int a = 11; a < 16; a++) begin
            rd(4'(a), r); chk("R11 unmapped offset", r, 0);
        end

        wr(4'd9, 16'h0002);
        chk("R8 done drops", reset_done, 0);
        rd(4'd10, r); chk("R8 status reads busy", r, 0);
        wr(4'd3, 16'h0080);
        chk("R8 done low cycle 2", reset_done, 0);
        @(negedge clk);
        chk("R8 done low cycle 3", reset_done, 0);
        @(negedge clk);
        chk("R8 done high cycle 4", reset_done, 1);
        rd(4'd10, r); chk("R8 status done", r, 16'h1);
        rd(4'd3, r); chk("R8 lcr cleared, busy write dropped", r, 0);
        rd(4'd8, r); chk("R8 mode field default", r, 16'h7);
        chk("R8 outputs default", {fifo_en, engine_en, irq_en, modem_ctrl, trig_lvl, tx_ctl}, 0);
        @(negedge clk);
        chk("R8 divisor from cleared latches", divisor, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule